// File: doc/BRIEF.md
# Double-Pumped Wavefront Issue Sequencer

This block sits between a half-rate instruction front end and a 16-lane ALU array. The front end takes in one decoded instruction per front-end cycle. That instruction carries operands for all 32 threads of a wavefront. The sequencer runs the instruction as two consecutive ALU beats. The first beat drives threads 0 to 15 onto the lanes and the second beat drives threads 16 to 31. The front end advances only on alternate ALU cycles. The block creates this half-rate strobe itself and exports it as a clock enable, so the front end stays in phase with the beats.

Each ALU result comes back on the same cycle as its beat. The sequencer registers that result into a writeback stage and drives one write enable per lane. A lane's enable is gated by the thread's bit in the wavefront active mask. A front-end cycle with no instruction offered leaves both following beats empty.

Top module: `wave_issue_seq`

## Requirements
- R1: `fe_en_o` is high in the first cycle after reset is released and inverts on every clock edge from then on.
- R2: `instr_ready_o` equals `fe_en_o`. An instruction is accepted only on an edge where `instr_valid_i` and `instr_ready_o` are both high. An instruction offered while `fe_en_o` is low is ignored, so no beat is issued for it.
- R3: An instruction accepted on an edge issues beat 0 in the next cycle and beat 1 in the cycle after that. During beat 0, `alu_valid_o`=1, `beat_id_o`=0 and `lane_opnd_o` lane l carries thread l. During beat 1, `beat_id_o`=1 and lane l carries thread 16+l. Thread t's operand is `instr_opnd_i[t*DATA_W +: DATA_W]`. `alu_op_o` holds the opcode during both beats.
- R4: `wave_done_o` is high exactly in the beat-1 cycle of each instruction and low otherwise.
- R5: During a beat, `lane_act_o[l]` equals mask bit l on beat 0 and mask bit 16+l on beat 1. Bit t of `instr_mask_i` belongs to thread t.
- R6: One cycle after each beat, `wr_valid_o`=1. In that cycle `wr_beat_o` equals the beat's id, `wr_dst_o` equals the instruction's destination, and `wr_data_o` equals the `alu_res_i` value present during the beat.
- R7: `wr_en_o[l]` is 1 only in a writeback cycle whose thread in lane l has its mask bit set. It is 0 for inactive threads and 0 in every cycle where `wr_valid_o` is low.
- R8: If no valid instruction is offered on a front-end cycle, both following cycles have `alu_valid_o`=0 and `wave_done_o`=0. The cycles after those have all write enables low.
- R9: Instructions accepted on consecutive front-end cycles issue with no idle cycle between them: beat 0 of the second directly follows beat 1 of the first.
- R10: While `rst_ni` is low, `alu_valid_o`, `wave_done_o`, `wr_valid_o` and `wr_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ALU-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fe_en_o | output | 1 | Half-rate front-end clock enable |
| instr_valid_i | input | 1 | Instruction offered |
| instr_ready_o | output | 1 | Instruction can be taken this cycle |
| instr_op_i | input | OP_W | Opcode |
| instr_dst_i | input | DST_W | Destination register index |
| instr_mask_i | input | 2*LANES | Per-thread active mask |
| instr_opnd_i | input | 2*LANES*DATA_W | Operands for all threads of the wavefront |
| alu_valid_o | output | 1 | A beat is on the lanes |
| alu_op_o | output | OP_W | Opcode for the current beat |
| beat_id_o | output | 1 | Wavefront half on the lanes (0 low, 1 high) |
| wave_done_o | output | 1 | Last beat of the instruction |
| lane_act_o | output | LANES | Active-thread flags for the current beat |
| lane_opnd_o | output | LANES*DATA_W | Lane operands for the current beat |
| alu_res_i | input | LANES*DATA_W | Lane results for the current beat |
| wr_valid_o | output | 1 | Writeback stage holds a beat |
| wr_beat_o | output | 1 | Beat id of the writeback |
| wr_dst_o | output | DST_W | Writeback destination |
| wr_en_o | output | LANES | Per-lane write enables |
| wr_data_o | output | LANES*DATA_W | Per-lane write data |

## Verification
The assertions assume that `alu_res_i` is a pure function of the current lane outputs. They also assume that the front end presents its fields steadily from one clock edge to the next, and that reset is held through at least one edge before release. The bench stands in for the ALU with an adder of operand and opcode and drives every input at the falling edge. It runs stretches of constant offers, no offers, pseudo-random offers with edge-case masks (empty, full, one half only, alternating), and offers placed only on off-phase cycles. Expected lanes, enables and write data come from a small arithmetic model of the beat timing.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned BEATS = 2;

  typedef enum logic {
    BEAT_LO = 1'b0,
    BEAT_HI = 1'b1
  } beat_e;
endpackage

// File: rtl/wis_phase.sv
module wis_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fe_o
);
  logic fe_q;

  // high in the first cycle after reset, then alternates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fe_q <= 1'b1;
    else         fe_q <= ~fe_q;
  end

  assign fe_o = fe_q;
endmodule

// File: rtl/wis_seq.sv
module wis_seq
  import wis_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  output logic  busy_o,
  output beat_e beat_o
);
  logic  busy_q, busy_d;
  beat_e beat_q, beat_d;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    if (busy_q && beat_q == BEAT_LO) begin
      beat_d = BEAT_HI;
    end else if (acc_i) begin
      busy_d = 1'b1;
      beat_d = BEAT_LO;
    end else begin
      busy_d = 1'b0;
      beat_d = BEAT_LO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= BEAT_LO;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/wis_hold.sv
module wis_hold #(
  parameter int unsigned OP_W    = 4,
  parameter int unsigned DST_W   = 5,
  parameter int unsigned THREADS = 32,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned OPND_W = THREADS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic [THREADS-1:0] mask_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic [OP_W-1:0]   op_o,
  output logic [DST_W-1:0]  dst_o,
  output logic [THREADS-1:0] mask_o,
  output logic [OPND_W-1:0] opnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= '0;
      dst_o  <= '0;
      mask_o <= '0;
      opnd_o <= '0;
    end else if (load_i) begin
      op_o   <= op_i;
      dst_o  <= dst_i;
      mask_o <= mask_i;
      opnd_o <= opnd_i;
    end
  end
endmodule

// File: rtl/wis_half_sel.sv
module wis_half_sel
  import wis_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned THREADS = LANES * BEATS
) (
  input  beat_e                       beat_i,
  input  logic [THREADS-1:0]          mask_i,
  input  logic [THREADS*DATA_W-1:0]   opnd_i,
  output logic [LANES-1:0]            act_o,
  output logic [LANES*DATA_W-1:0]     opnd_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign act_o[l] = (beat_i == BEAT_HI) ? mask_i[LANES+l] : mask_i[l];
    assign opnd_o[l*DATA_W +: DATA_W] = (beat_i == BEAT_HI)
        ? opnd_i[(LANES+l)*DATA_W +: DATA_W]
        : opnd_i[l*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/wis_wb.sv
module wis_wb #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DST_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic                     beat_i,
  input  logic [DST_W-1:0]         dst_i,
  input  logic [LANES-1:0]         act_i,
  input  logic [LANES*DATA_W-1:0]  res_i,
  output logic                     vld_o,
  output logic                     beat_o,
  output logic [DST_W-1:0]         dst_o,
  output logic [LANES-1:0]         en_o,
  output logic [LANES*DATA_W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      beat_o <= 1'b0;
      dst_o  <= '0;
      en_o   <= '0;
      data_o <= '0;
    end else begin
      vld_o  <= vld_i;
      beat_o <= beat_i;
      dst_o  <= dst_i;
      en_o   <= vld_i ? act_i : '0;
      data_o <= res_i;
    end
  end
endmodule

// File: rtl/wave_issue_seq.sv
module wave_issue_seq
  import wis_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DST_W  = 5,
  localparam int unsigned THREADS = LANES * BEATS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic                        fe_en_o,
  input  logic                        instr_valid_i,
  output logic                        instr_ready_o,
  input  logic [OP_W-1:0]             instr_op_i,
  input  logic [DST_W-1:0]            instr_dst_i,
  input  logic [THREADS-1:0]          instr_mask_i,
  input  logic [THREADS*DATA_W-1:0]   instr_opnd_i,
  output logic                        alu_valid_o,
  output logic [OP_W-1:0]             alu_op_o,
  output logic                        beat_id_o,
  output logic                        wave_done_o,
  output logic [LANES-1:0]            lane_act_o,
  output logic [LANES*DATA_W-1:0]     lane_opnd_o,
  input  logic [LANES*DATA_W-1:0]     alu_res_i,
  output logic                        wr_valid_o,
  output logic                        wr_beat_o,
  output logic [DST_W-1:0]            wr_dst_o,
  output logic [LANES-1:0]            wr_en_o,
  output logic [LANES*DATA_W-1:0]     wr_data_o
);
  logic                      fe;
  logic                      acc;
  logic                      busy;
  beat_e                     beat;
  logic [DST_W-1:0]          dst_q;
  logic [THREADS-1:0]        mask_q;
  logic [THREADS*DATA_W-1:0] opnd_q;

  wis_phase i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fe_o   (fe)
  );

  // seq only reaches a beat boundary on front-end cycles
  assign acc = instr_valid_i & fe;

  wis_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .busy_o (busy),
    .beat_o (beat)
  );

  wis_hold #(
    .OP_W    (OP_W),
    .DST_W   (DST_W),
    .THREADS (THREADS),
    .DATA_W  (DATA_W)
  ) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc),
    .op_i   (instr_op_i),
    .dst_i  (instr_dst_i),
    .mask_i (instr_mask_i),
    .opnd_i (instr_opnd_i),
    .op_o   (alu_op_o),
    .dst_o  (dst_q),
    .mask_o (mask_q),
    .opnd_o (opnd_q)
  );

  wis_half_sel #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
  ) i_half (
    .beat_i (beat),
    .mask_i (mask_q),
    .opnd_i (opnd_q),
    .act_o  (lane_act_o),
    .opnd_o (lane_opnd_o)
  );

  wis_wb #(
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .DST_W  (DST_W)
  ) i_wb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (busy),
    .beat_i (beat == BEAT_HI),
    .dst_i  (dst_q),
    .act_i  (lane_act_o),
    .res_i  (alu_res_i),
    .vld_o  (wr_valid_o),
    .beat_o (wr_beat_o),
    .dst_o  (wr_dst_o),
    .en_o   (wr_en_o),
    .data_o (wr_data_o)
  );

  assign fe_en_o       = fe;
  assign instr_ready_o = fe;
  assign alu_valid_o   = busy;
  assign beat_id_o     = (beat == BEAT_HI);
  assign wave_done_o   = busy & (beat == BEAT_HI);
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int unsigned LANES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fe_en_o,
  input logic             instr_valid_i,
  input logic             instr_ready_o,
  input logic             alu_valid_o,
  input logic             beat_id_o,
  input logic             wave_done_o,
  input logic [LANES-1:0] lane_act_o,
  input logic             wr_valid_o,
  input logic             wr_beat_o,
  input logic [LANES-1:0] wr_en_o
);
  AST_FE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_en_o |=> !fe_en_o); // R1
  AST_FE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fe_en_o |=> fe_en_o); // R1
  AST_ACCEPT_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o) |=> (alu_valid_o && !beat_id_o)); // R3
  AST_BEAT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_o && !beat_id_o) |=> (alu_valid_o && beat_id_o)); // R3
  AST_DONE_AFTER_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_o && !beat_id_o) |=> wave_done_o); // R4
  AST_NO_OFFER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_en_o && !instr_valid_i) |=> !alu_valid_o); // R8
  AST_WB_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |=> (wr_valid_o && wr_beat_o == $past(beat_id_o))); // R6
  AST_WEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |=> (wr_en_o == $past(lane_act_o))); // R7
  AST_WEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> (wr_en_o == '0)); // R7
  AST_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_done_o && instr_valid_i && instr_ready_o) |=> (alu_valid_o && !beat_id_o)); // R9
endmodule

bind wave_issue_seq wis_checker #(.LANES(LANES)) i_wis_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fe_en_o       (fe_en_o),
  .instr_valid_i (instr_valid_i),
  .instr_ready_o (instr_ready_o),
  .alu_valid_o   (alu_valid_o),
  .beat_id_o     (beat_id_o),
  .wave_done_o   (wave_done_o),
  .lane_act_o    (lane_act_o),
  .wr_valid_o    (wr_valid_o),
  .wr_beat_o     (wr_beat_o),
  .wr_en_o       (wr_en_o)
);

// File: tb/test_wave_issue_seq.sv
`timescale 1ns/1ps
module test_wave_issue_seq;
  localparam int LANES = 16, DATA_W = 16, OP_W = 4, DST_W = 5;
  localparam int THREADS = 2 * LANES;
  localparam int OPND_W = THREADS * DATA_W;
  localparam int LW = LANES * DATA_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fe_en_o, instr_valid_i, instr_ready_o;
  logic [OP_W-1:0] instr_op_i, alu_op_o;
  logic [DST_W-1:0] instr_dst_i, wr_dst_o;
  logic [THREADS-1:0] instr_mask_i;
  logic [OPND_W-1:0] instr_opnd_i;
  logic alu_valid_o, beat_id_o, wave_done_o, wr_valid_o, wr_beat_o;
  logic [LANES-1:0] lane_act_o, wr_en_o;
  logic [LW-1:0] lane_opnd_o, alu_res_i, wr_data_o;

  always #4 clk_i = ~clk_i;

  wave_issue_seq i_wave_issue_seq (.*);

  // stand-in ALU: result = operand + opcode
  always_comb
    for (int l = 0; l < LANES; l++)
      alu_res_i[l*DATA_W +: DATA_W] = lane_opnd_o[l*DATA_W +: DATA_W] + DATA_W'(alu_op_o);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [OPND_W-1:0] act,
                     input logic [OPND_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  bit m_fe, m_busy, m_beat, m_wv, m_wbeat, m_b2b;
  logic [OP_W-1:0] h_op;
  logic [DST_W-1:0] h_dst, m_wdst;
  logic [THREADS-1:0] h_mask;
  logic [OPND_W-1:0] h_opnd;
  logic [LANES-1:0] m_wen;
  logic [LW-1:0] m_wdata;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [LANES-1:0] mhalf(logic [THREADS-1:0] m, bit b);
    return b ? m[THREADS-1:LANES] : m[LANES-1:0];
  endfunction
  function automatic logic [LW-1:0] ohalf(logic [OPND_W-1:0] o, bit b);
    return b ? o[OPND_W-1:LW] : o[LW-1:0];
  endfunction
  function automatic logic [LW-1:0] addop(logic [LW-1:0] o, logic [OP_W-1:0] op);
    logic [LW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DATA_W +: DATA_W] = o[l*DATA_W +: DATA_W] + DATA_W'(op);
    return r;
  endfunction

  task automatic step_lcg();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic model_edge();
    bit acc, was_b1;
    m_wv = m_busy;
    m_wbeat = m_beat;
    m_wdst = h_dst;
    m_wen = m_busy ? mhalf(h_mask, m_beat) : '0;
    m_wdata = addop(ohalf(h_opnd, m_beat), h_op);
    acc = m_fe && instr_valid_i;
    was_b1 = m_busy && m_beat;
    m_b2b = was_b1 && acc;
    if (m_busy && !m_beat) m_beat = 1;
    else if (acc) begin
      m_busy = 1; m_beat = 0;
      h_op = instr_op_i; h_dst = instr_dst_i; h_mask = instr_mask_i; h_opnd = instr_opnd_i;
    end else begin
      m_busy = 0; m_beat = 0;
    end
    m_fe = !m_fe;
  endtask

  task automatic check_all();
    chk(fe_en_o == m_fe, "R1 fe_en", OPND_W'(fe_en_o), OPND_W'(m_fe));
    chk(instr_ready_o == m_fe, "R2 ready", OPND_W'(instr_ready_o), OPND_W'(m_fe));
    chk(alu_valid_o == m_busy, m_busy ? "R3 alu_valid" : "R8 alu_valid idle",
        OPND_W'(alu_valid_o), OPND_W'(m_busy));
    chk(wave_done_o == (m_busy && m_beat), "R4 wave_done",
        OPND_W'(wave_done_o), OPND_W'(m_busy && m_beat));
    if (m_busy) begin
      chk(beat_id_o == m_beat, "R3 beat_id", OPND_W'(beat_id_o), OPND_W'(m_beat));
      chk(alu_op_o == h_op, "R3 alu_op", OPND_W'(alu_op_o), OPND_W'(h_op));
      chk(lane_opnd_o == ohalf(h_opnd, m_beat), "R3 lane_opnd",
          OPND_W'(lane_opnd_o), OPND_W'(ohalf(h_opnd, m_beat)));
      chk(lane_act_o == mhalf(h_mask, m_beat), "R5 lane_act",
          OPND_W'(lane_act_o), OPND_W'(mhalf(h_mask, m_beat)));
    end
    if (m_b2b)
      chk(alu_valid_o && !beat_id_o, "R9 back-to-back beat 0",
          OPND_W'({alu_valid_o, beat_id_o}), OPND_W'(2'b10));
    chk(wr_valid_o == m_wv, "R6 wr_valid", OPND_W'(wr_valid_o), OPND_W'(m_wv));
    chk(wr_en_o == m_wen, "R7 wr_en", OPND_W'(wr_en_o), OPND_W'(m_wen));
    if (m_wv) begin
      chk(wr_beat_o == m_wbeat, "R6 wr_beat", OPND_W'(wr_beat_o), OPND_W'(m_wbeat));
      chk(wr_dst_o == m_wdst, "R6 wr_dst", OPND_W'(wr_dst_o), OPND_W'(m_wdst));
      chk(wr_data_o == m_wdata, "R6 wr_data", OPND_W'(wr_data_o), OPND_W'(m_wdata));
    end
  endtask

  task automatic drive(input int i);
    logic [THREADS-1:0] mk;
    bit v;
    step_lcg();
    for (int t = 0; t < THREADS; t++) begin
      step_lcg();
      instr_opnd_i[t*DATA_W +: DATA_W] = lcg[31:16];
    end
    instr_op_i = lcg[7:4];
    instr_dst_i = lcg[12:8];
    step_lcg();
    mk = lcg;
    case (i % 5)
      0: mk = '0;
      1: mk = 32'h0000_FFFF;
      2: mk = 32'hFFFF_0000;
      3: mk = 32'h5555_5555;
      default: ;
    endcase
    if (i < 80)       begin v = 1; mk = '1; end
    else if (i < 160) v = 0;
    else if (i < 400) v = lcg[20];
    else if (i < 480) v = !m_fe;   // offered only off-phase: must be ignored (R2)
    else              v = 1;
    instr_valid_i = v;
    instr_mask_i = mk;
  endtask

  initial begin
    instr_valid_i = 0; instr_op_i = '0; instr_dst_i = '0;
    instr_mask_i = '0; instr_opnd_i = '0;
    m_fe = 1; m_busy = 0; m_beat = 0; m_wv = 0; m_wbeat = 0; m_b2b = 0;
    h_op = '0; h_dst = '0; h_mask = '0; h_opnd = '0;
    m_wen = '0; m_wdst = '0; m_wdata = '0;
    repeat (3) @(negedge clk_i);
    instr_valid_i = 1;  // offered during reset: must not issue
    @(negedge clk_i);
    chk(!alu_valid_o, "R10 alu_valid in reset", OPND_W'(alu_valid_o), '0);
    chk(!wave_done_o, "R10 wave_done in reset", OPND_W'(wave_done_o), '0);
    chk(!wr_valid_o, "R10 wr_valid in reset", OPND_W'(wr_valid_o), '0);
    chk(wr_en_o == '0, "R10 wr_en in reset", OPND_W'(wr_en_o), '0);
    rst_ni = 1;
    #0;
    chk(fe_en_o == 1'b1, "R1 fe_en first cycle", OPND_W'(fe_en_o), OPND_W'(1));
    drive(0);
    for (int i = 1; i < 560; i++) begin
      @(negedge clk_i);
      model_edge();
      check_all();
      drive(i);
    end
    @(negedge clk_i); model_edge(); check_all();
    instr_valid_i = 0;
    repeat (4) begin @(negedge clk_i); model_edge(); check_all(); end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule